// File: doc/BRIEF.md
# LIN Break Field Transmitter

This block is the transmit half of an asynchronous serial port that can also emit a LIN synchronous break. A small register-style interface gives it a power bit, a transmit-enable bit, a self-clearing break-start bit and a 3-bit break length. Bit timing comes from a one-cycle baud tick supplied from outside. When a break is requested, the line goes low at the next tick and stays low for 13 to 20 bit times. The block then pulses a completion interrupt, clears the start bit itself and returns to normal transmit mode.

Normal traffic is a plain 8N1 frame taken from a one-byte transmit buffer. A frame ends with the same completion pulse as a break. A request made while the block is busy waits and is served when the current operation ends. Removing power aborts whatever is running and returns the line to the high level.

Top module: `lin_brk_tx`

## Requirements
- R1: While `rstN` is low or `powerOn` is 0, `txLine` is 1 and `busy`, `brkStartBit` and `txDoneIrq` are 0. Clearing `powerOn` during a break or a frame aborts it, so that one clock later the line is high and nothing is pending.
- R2: `brkReq` and `wrData` pulses are ignored unless `powerOn` and `txEnable` are both 1. No operation starts at a tick unless both are 1.
- R3: An accepted `brkReq` sets `brkStartBit` on the next clock. The first `baudTick` after that drives `txLine` to 0 and raises `busy`.
- R4: The line stays low for exactly `brkLen`+13 baud ticks, counting the tick that started the break. This gives 13 for `brkLen`=0 and 20 for `brkLen`=7.
- R5: The tick that ends a break or a frame raises `txDoneIrq` for exactly one clock. In that same cycle `busy` drops and `txLine` is 1. At the end of a break `brkStartBit` is cleared unless another break is waiting.
- R6: A data frame sends a 0 start bit on the first tick after the byte is buffered. The 8 data bits follow on the next 8 ticks, least significant bit first, then a 1 stop bit on the next tick. The completion pulse comes on the tick after the stop bit.
- R7: After an operation ends with nothing pending, `txLine` stays 1 and no interrupt occurs on later ticks.
- R8: A break request or byte write accepted while the block is busy is held. It starts on the first tick after the completion pulse.
- R9: When a break and a byte are both waiting, the break is sent first and the byte follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse per bit time |
| powerOn | input | 1 | Power control; 0 aborts and idles the line high |
| txEnable | input | 1 | Transmit enable |
| brkReq | input | 1 | Write-one pulse to the break-start bit |
| brkLen | input | 3 | Break length selector (length = value + 13 bit times) |
| wrData | input | 1 | Write pulse to the transmit buffer |
| wrByte | input | 8 | Byte written to the transmit buffer |
| txLine | output | 1 | Serial transmit line |
| txDoneIrq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | High from the start of a break or frame until its interrupt |
| brkStartBit | output | 1 | Readback of the self-clearing break-start bit |

## Verification
A wrong bit count inside the block shows up directly as a break that is one or more bit times too short or too long, or as a frame whose bits are misplaced. Each of these is visible on `txLine` at the first tick where the count diverges. A start bit that fails to clear, or a held request that is lost, becomes visible one tick after the completion pulse. At that tick the line either drops when it should stay high, or stays high when it should drop. A stuck abort or power path shows within one clock of `powerOn` falling, as a low line or a `busy` flag that stays set.

// File: rtl/lin_brk_tx_pkg.sv
package lin_brk_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BRK  = 2'd1,
    ST_DATA = 2'd2
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic abort;     // power removed: idle line, clear counter
    logic loadBrk;   // begin break, capture length
    logic loadData;  // begin frame, capture byte
    logic countBit;  // one break bit time elapsed
    logic shiftBit;  // next frame bit onto the line
    logic finish;    // end of break/frame
  } txStrobe_t;

endpackage

// File: rtl/lin_brk_tx_dp.sv
module lin_brk_tx_dp
  import lin_brk_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 3,
  parameter int BRK_MIN = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [LEN_W-1:0]  brkLen,
  input  logic [DATA_W-1:0] frameByte,
  output logic              txLine,
  output logic              brkDone,
  output logic              frmDone
);

  localparam int BRK_MAX  = BRK_MIN + (1 << LEN_W) - 2;
  localparam int FRM_LAST = DATA_W + 1;
  localparam int CNT_MAX  = (BRK_MAX > FRM_LAST) ? BRK_MAX : FRM_LAST;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  lenLim;
  logic [DATA_W:0]   shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLine <= 1'b1;
      bitCnt <= '0;
      lenLim <= '0;
      shReg  <= '0;
    end else if (strobe.abort) begin
      txLine <= 1'b1;
      bitCnt <= '0;
    end else if (strobe.loadBrk) begin
      txLine <= 1'b0;
      bitCnt <= '0;
      lenLim <= CNT_W'(BRK_MIN - 1) + CNT_W'(brkLen);
    end else if (strobe.loadData) begin
      txLine <= 1'b0;
      bitCnt <= '0;
      shReg  <= {1'b1, frameByte};
    end else if (strobe.finish) begin
      txLine <= 1'b1;
      bitCnt <= '0;
    end else if (strobe.shiftBit) begin
      txLine <= shReg[0];
      shReg  <= shReg >> 1;
      bitCnt <= bitCnt + 1'b1;
    end else if (strobe.countBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign brkDone = (bitCnt == lenLim);
  assign frmDone = (bitCnt == CNT_W'(FRM_LAST));

  // R1
  abort_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> txLine);

  // R3
  load_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.abort && (strobe.loadBrk || strobe.loadData)) |=> !txLine);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX));

  // R5
  finish_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> txLine);

endmodule

// File: rtl/lin_brk_tx_ctrl.sv
module lin_brk_tx_ctrl
  import lin_brk_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              powerOn,
  input  logic              txEnable,
  input  logic              brkReq,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              brkDone,
  input  logic              frmDone,
  output txStrobe_t         strobe,
  output logic [DATA_W-1:0] frameByte,
  output logic              txDoneIrq,
  output logic              busy,
  output logic              brkStartBit
);

  txState_e          state;
  logic              brkHeld;
  logic              dataFull;
  logic [DATA_W-1:0] dataBuf;
  logic              enabled;
  logic              acceptBrk;
  logic              acceptWr;

  assign enabled   = powerOn && txEnable;
  assign acceptBrk = brkReq && enabled;
  assign acceptWr  = wrData && enabled;
  assign frameByte = dataBuf;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.abort = !powerOn;
    if (powerOn && baudTick) begin
      unique case (state)
        ST_IDLE: begin
          if (enabled && brkStartBit)   strobe.loadBrk  = 1'b1;
          else if (enabled && dataFull) strobe.loadData = 1'b1;
        end
        ST_BRK: begin
          if (brkDone) strobe.finish   = 1'b1;
          else         strobe.countBit = 1'b1;
        end
        ST_DATA: begin
          if (frmDone) strobe.finish   = 1'b1;
          else         strobe.shiftBit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      brkStartBit <= 1'b0;
      brkHeld     <= 1'b0;
      dataFull    <= 1'b0;
      dataBuf     <= '0;
      txDoneIrq   <= 1'b0;
    end else if (!powerOn) begin
      state       <= ST_IDLE;
      brkStartBit <= 1'b0;
      brkHeld     <= 1'b0;
      dataFull    <= 1'b0;
      txDoneIrq   <= 1'b0;
    end else begin
      txDoneIrq <= strobe.finish;

      if (strobe.loadBrk)       state <= ST_BRK;
      else if (strobe.loadData) state <= ST_DATA;
      else if (strobe.finish)   state <= ST_IDLE;

      if (strobe.finish && state == ST_BRK) begin
        brkStartBit <= brkHeld || acceptBrk;
        brkHeld     <= 1'b0;
      end else if (acceptBrk) begin
        if (state == ST_BRK) brkHeld     <= 1'b1;
        else                 brkStartBit <= 1'b1;
      end

      if (acceptWr) begin
        dataBuf  <= wrByte;
        dataFull <= 1'b1;
      end else if (strobe.loadData) begin
        dataFull <= 1'b0;
      end
    end
  end

  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |=> !txDoneIrq);

  // R5
  busy_fall_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(powerOn)) |-> txDoneIrq);

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> (!busy && !brkStartBit && !txDoneIrq));

  // R2
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !txEnable) |=> !busy);

endmodule

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
  import lin_brk_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 3,
  parameter int BRK_MIN = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              powerOn,
  input  logic              txEnable,
  input  logic              brkReq,
  input  logic [LEN_W-1:0]  brkLen,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrByte,
  output logic              txLine,
  output logic              txDoneIrq,
  output logic              busy,
  output logic              brkStartBit
);

  txStrobe_t         strobe;
  logic [DATA_W-1:0] frameByte;
  logic              brkDone;
  logic              frmDone;

  lin_brk_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .powerOn    (powerOn),
    .txEnable   (txEnable),
    .brkReq     (brkReq),
    .wrData     (wrData),
    .wrByte     (wrByte),
    .brkDone    (brkDone),
    .frmDone    (frmDone),
    .strobe     (strobe),
    .frameByte  (frameByte),
    .txDoneIrq  (txDoneIrq),
    .busy       (busy),
    .brkStartBit(brkStartBit)
  );

  lin_brk_tx_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BRK_MIN(BRK_MIN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .brkLen   (brkLen),
    .frameByte(frameByte),
    .txLine   (txLine),
    .brkDone  (brkDone),
    .frmDone  (frmDone)
  );

  // R5
  irq_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |-> (txLine && !busy));

endmodule

// File: tb/lin_brk_tx_bench.sv
`timescale 1ns/1ps
module lin_brk_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       powerOn = 1'b0;
  logic       txEnable = 1'b0;
  logic       brkReq = 1'b0;
  logic [2:0] brkLen = 3'd0;
  logic       wrData = 1'b0;
  logic [7:0] wrByte = 8'd0;
  logic       txLine, txDoneIrq, busy, brkStartBit;

  int nChk = 0;
  int nBad = 0;
  logic tLine, tIrq, tBusy;
  int lowCnt;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  lin_brk_tx u_lin_brk_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .powerOn(powerOn),
    .txEnable(txEnable), .brkReq(brkReq), .brkLen(brkLen), .wrData(wrData),
    .wrByte(wrByte), .txLine(txLine), .txDoneIrq(txDoneIrq), .busy(busy),
    .brkStartBit(brkStartBit)
  );

  // {isFrame, value}: break length code or data byte
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'd0}, {1'b1, 8'hA5}, {1'b0, 8'd7}, {1'b1, 8'h00},
    {1'b0, 8'd3}, {1'b1, 8'hFF}, {1'b0, 8'd5}, {1'b1, 8'h3C}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
    tLine = txLine; tIrq = txDoneIrq; tBusy = busy;
    repeat (2) @(negedge clk);
  endtask

  // count low ticks until the completion pulse
  task automatic runToIrq();
    for (int i = 0; i < 40; i++) begin
      pulse();
      if (tIrq) break;
      if (!tLine) lowCnt++;
    end
  endtask

  task automatic reqBreak(input logic [2:0] len);
    @(negedge clk) brkLen = len; brkReq = 1'b1;
    @(negedge clk) brkReq = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk) wrByte = b; wrData = 1'b1;
    @(negedge clk) wrData = 1'b0;
  endtask

  task automatic collectByte();
    for (int i = 0; i < 8; i++) begin
      pulse();
      got[i] = tLine;
    end
  endtask

  task automatic idleCheck();
    for (int i = 0; i < 2; i++) begin
      pulse();
      check(tLine && !tIrq && !tBusy, "R7", {tLine, tIrq, tBusy}, 3'b100);
    end
  endtask

  task automatic runBreak(input logic [2:0] len);
    reqBreak(len);
    check(brkStartBit == 1'b1 && txLine == 1'b1, "R3", {brkStartBit, txLine}, 2'b11);
    pulse();
    check(!tLine && tBusy, "R3", {tLine, tBusy}, 2'b01);
    lowCnt = 1;
    runToIrq();
    check(lowCnt == int'(len) + 13, "R4", lowCnt, int'(len) + 13);
    check(tIrq && tLine && !tBusy && !brkStartBit, "R5",
          {tIrq, tLine, tBusy, brkStartBit}, 4'b1100);
    idleCheck();
  endtask

  task automatic runFrame(input logic [7:0] b);
    writeByte(b);
    pulse();
    check(!tLine && tBusy, "R6", {tLine, tBusy}, 2'b01);
    collectByte();
    check(got == b, "R6", got, b);
    pulse();
    check(tLine && !tIrq && tBusy, "R6", {tLine, tIrq, tBusy}, 3'b101);
    pulse();
    check(tIrq && tLine && !tBusy, "R5", {tIrq, tLine, tBusy}, 3'b110);
    idleCheck();
  endtask

  initial begin
    #1000000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txLine && !busy && !txDoneIrq && !brkStartBit, "R1",
          {txLine, busy, txDoneIrq, brkStartBit}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine && !busy && !brkStartBit, "R1", {txLine, busy, brkStartBit}, 3'b100);

    // requests ignored while transmit not enabled
    powerOn = 1'b1;
    reqBreak(3'd0);
    writeByte(8'h81);
    check(!brkStartBit, "R2", brkStartBit, 0);
    pulse();
    check(tLine && !tBusy, "R2", {tLine, tBusy}, 2'b10);
    txEnable = 1'b1;
    pulse();
    check(tLine && !tBusy && !tIrq, "R2", {tLine, tBusy, tIrq}, 3'b100);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][8]) runFrame(VEC[v][7:0]);
      else           runBreak(VEC[v][2:0]);
    end

    // break request during a break is held
    runBreakHeld();

    // break and byte both waiting: break first
    writeByte(8'h55);
    reqBreak(3'd0);
    pulse();
    check(!tLine && tBusy, "R9", {tLine, tBusy}, 2'b01);
    lowCnt = 1;
    runToIrq();
    check(lowCnt == 13 && tIrq, "R9", lowCnt, 13);
    pulse();
    check(!tLine && tBusy, "R8", {tLine, tBusy}, 2'b01);
    collectByte();
    check(got == 8'h55, "R9", got, 8'h55);
    pulse();
    pulse();
    check(tIrq && !tBusy, "R5", {tIrq, tBusy}, 2'b10);

    // abort by power removal
    writeByte(8'h0F);
    pulse();
    pulse();
    reqBreak(3'd2);
    @(negedge clk) powerOn = 1'b0;
    @(negedge clk);
    check(txLine && !busy && !brkStartBit, "R1", {txLine, busy, brkStartBit}, 3'b100);
    powerOn = 1'b1;
    pulse();
    check(tLine && !tBusy, "R1", {tLine, tBusy}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  task automatic runBreakHeld();
    reqBreak(3'd0);
    pulse();
    pulse();
    pulse();
    reqBreak(3'd1);
    lowCnt = 3;
    runToIrq();
    check(tIrq && brkStartBit, "R8", {tIrq, brkStartBit}, 2'b11);
    pulse();
    check(!tLine && tBusy, "R8", {tLine, tBusy}, 2'b01);
    lowCnt = 1;
    runToIrq();
    check(lowCnt == 14 && !brkStartBit, "R8", lowCnt, 14);
  endtask

endmodule